// File: doc/BRIEF.md
# Muxed Module Clock Generator

This block derives a slower module clock from one of several source rates. Each source is an enable strobe that lives in a single fast clock domain. A single 32-bit control register picks the source and sets the division. The selected strobe passes through a power-of-two prescaler and then through a linear divider. The result appears in two forms: a one-cycle clock-enable pulse once per output period, and a level output that is high for about half of each period. The generator can only divide, so the output rate never exceeds the rate of the selected source.

Software programs the block through a byte-addressed write port with per-byte strobes and reads it back through a combinational read port. Changes to the division factors wait for the next period boundary. Clearing the enable lets the current high phase finish, so neither output is ever cut short. A new source selection restarts counting from zero.

Top module: `modclk_gen`

## Requirements
- R1: After reset the register reads 0, `clk_en` is 0 and `clk_out` is 0. Strobes have no effect while the enable bit is 0 and `clk_out` is low.
- R2: The register sits at byte address `REG_ADDR` (0 by default). Only the enable (bit 31), select (bits 24 upward, `$clog2(NUM_SRC)` bits, i.e. 27:24 by default), prescale exponent p (bits 17:16) and divider m (bits 3:0) are stored. Every other bit reads 0 and ignores writes. Each `wr_be[b]` gates byte b. Writes to other addresses have no effect, and reads of other addresses return 0.
- R3: With N = 2^p·(m+1), `clk_en` pulses for one cycle in the cycle after every N-th strobe of the selected source, counted from the moment counting started.
- R4: Only `src_tick[sel]` advances the counters. Strobes on all other sources are ignored.
- R5: `clk_out` rises together with each `clk_en` pulse. For N ≥ 2 it falls after the strobe with index N/2−1 (integer division) of the next period, and the first period after a start is low throughout. For N = 1 it stays high.
- R6: A new p or m takes effect at the next period boundary. A write that lands in the same cycle as the period-closing strobe applies to the period that follows.
- R7: When the enable bit is cleared, `clk_out` finishes its high phase, then stays low with no further `clk_en` pulse. A `clk_en` pulse only follows a cycle in which the enable bit was set.
- R8: A write that changes the select field resets the prescale and divide counters. Counting restarts at zero on the new source.
- R9: `clk_en` is high only in the cycle right after a selected-source strobe, so the output rate never exceeds the source rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock shared by all source strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_be | input | 4 | Per-byte write strobes |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read data (combinational) |
| src_tick | input | NUM_SRC | Source rate strobes, one per source |
| clk_en | output | 1 | One-cycle pulse per output period |
| clk_out | output | 1 | Duty-balanced level output |

## Verification
Two functions can fall in the same cycle: the factor reload at the period boundary and a register write that changes the factors. The bench drives the write and the period-closing strobe on the same clock edge. It expects the pulse for the old period and the new length on the very next period. It also issues a select change mid-period and clears the enable during a high phase, then counts strobes up to the next pulse and watches the level output against values worked out from N.

// File: rtl/modclk_pkg.sv
// Shared constants and types for the muxed module clock generator.
// Field positions are fixed because software decodes them.
package modclk_pkg;

    localparam int REG_W     = 32;
    localparam int EN_POS    = 31;
    localparam int SEL_POS   = 24;
    localparam int SEL_MAX_W = 4;
    localparam int PRE_POS   = 16;
    localparam int PRE_W     = 2;
    localparam int DIV_POS   = 0;
    localparam int DIV_W     = 4;

    // Division factors as held in the register and in the active copy.
    typedef struct packed {
        logic [PRE_W-1:0] pexp;
        logic [DIV_W-1:0] mdiv;
    } mclk_fac_t;

endpackage

// File: rtl/modclk_regs.sv
// Control register with byte strobes and masked storage.
// Only the enable, select, prescale and divide bits exist; the rest read 0.
// Also exposes the next register value, so a reload in the same cycle as a write sees the written data.
// Assumes a single register at byte address REG_ADDR.
module modclk_regs
    import modclk_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int unsigned REG_ADDR = 0,
    parameter int          SEL_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_be,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              cfg_en,
    output logic [SEL_W-1:0]  cfg_sel,
    output mclk_fac_t         cfg_fac,
    output mclk_fac_t         nxt_fac,
    output logic              sel_chg
);

    function automatic logic [REG_W-1:0] used_mask();
        logic [REG_W-1:0] msk;
        msk = '0;
        msk[EN_POS] = 1'b1;
        for (int i = 0; i < SEL_W; i++) msk[SEL_POS+i] = 1'b1;
        for (int i = 0; i < PRE_W; i++) msk[PRE_POS+i] = 1'b1;
        for (int i = 0; i < DIV_W; i++) msk[DIV_POS+i] = 1'b1;
        return msk;
    endfunction

    localparam logic [REG_W-1:0]  USED_BITS = used_mask();
    localparam logic [ADDR_W-1:0] MY_ADDR   = ADDR_W'(REG_ADDR);

    logic [REG_W-1:0] ctl_q;
    logic [REG_W-1:0] ctl_nxt;
    logic             wr_hit;

    assign wr_hit = wr_en && (wr_addr == MY_ADDR);

    // Merge the strobed bytes of a write, then drop the bits that do not exist.
    always_comb begin
        ctl_nxt = ctl_q;
        if (wr_hit) begin
            for (int b = 0; b < 4; b++) begin
                if (wr_be[b]) ctl_nxt[8*b +: 8] = wr_data[8*b +: 8];
            end
        end
        ctl_nxt = ctl_nxt & USED_BITS;
    end

    // Register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_nxt;
    end

    assign rd_data      = (rd_addr == MY_ADDR) ? ctl_q : '0;
    assign cfg_en       = ctl_q[EN_POS];
    assign cfg_sel      = ctl_q[SEL_POS +: SEL_W];
    assign cfg_fac.pexp = ctl_q[PRE_POS +: PRE_W];
    assign cfg_fac.mdiv = ctl_q[DIV_POS +: DIV_W];
    assign nxt_fac.pexp = ctl_nxt[PRE_POS +: PRE_W];
    assign nxt_fac.mdiv = ctl_nxt[DIV_POS +: DIV_W];
    assign sel_chg      = ctl_nxt[SEL_POS +: SEL_W] != ctl_q[SEL_POS +: SEL_W];

    // R2
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~USED_BITS) == '0);

    // R2
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != MY_ADDR) |=> $stable(ctl_q));

endmodule

// File: rtl/modclk_src_sel.sv
// Source strobe selector. A select value beyond the last source
// picks a constant 0, so the output simply stops.
// Assumes every source strobe is synchronous to the fast clock.
module modclk_src_sel #(
    parameter int NUM_SRC = 16,
    parameter int SEL_W   = 4
) (
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   sel,
    output logic               strobe
);

    localparam int SLOTS = 1 << SEL_W;

    logic [SLOTS-1:0] padded;

    // Fill the power-of-two table; slots with no source read 0.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < NUM_SRC) begin : g_src
            assign padded[g] = src_tick[g];
        end else begin : g_none
            assign padded[g] = 1'b0;
        end
    end

    assign strobe = padded[sel];

endmodule

// File: rtl/modclk_prescale.sv
// Power-of-two prescaler. It counts input strobes and passes one in every 2^pexp.
// A synchronous clear returns it to the start of a group.
// Assumes pexp changes only while the counter is at zero or is being cleared.
module modclk_prescale #(
    parameter int EXP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             strobe,
    input  logic [EXP_W-1:0] pexp,
    output logic [((1<<EXP_W)-1)-1:0] cnt,
    output logic             pass
);

    localparam int CNT_W = (1 << EXP_W) - 1;

    logic [CNT_W-1:0] last_val;

    assign last_val = ~({CNT_W{1'b1}} << pexp);
    assign pass     = strobe && (cnt == last_val);

    // Advance on each strobe and wrap after the last one of a group.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (pass)      cnt <= '0;
        else if (strobe)    cnt <= cnt + CNT_W'(1);
    end

    // R3
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_val);

endmodule

// File: rtl/modclk_divide.sv
// Linear divider. It counts prescaled steps from 0 to mdiv and flags the step that closes a period.
// Assumes mdiv changes only on a wrap or a clear.
module modclk_divide #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [DIV_W-1:0] mdiv,
    output logic [DIV_W-1:0] cnt,
    output logic             wrap
);

    assign wrap = step && (cnt == mdiv);

    // Count steps and restart after the period-closing one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (wrap)     cnt <= '0;
        else if (step)     cnt <= cnt + DIV_W'(1);
    end

    // R3
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= mdiv);

endmodule

// File: rtl/modclk_gen.sv
// Muxed module clock generator, top level.
// It selects one source strobe, divides it by 2^p*(m+1) and produces an enable pulse
// and a duty-balanced level.
// The factors in use are copied from the register only at a period boundary or while idle.
// Assumes NUM_SRC <= 16 and that all strobes share clk.
module modclk_gen
    import modclk_pkg::*;
#(
    parameter int          NUM_SRC  = 16,
    parameter int          ADDR_W   = 8,
    parameter int unsigned REG_ADDR = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [3:0]         wr_be,
    input  logic [31:0]        wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [31:0]        rd_data,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               clk_en,
    output logic               clk_out
);

    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int PCNT_W = (1 << PRE_W) - 1;
    localparam int KW     = PCNT_W + DIV_W;
    localparam int NW     = KW + 1;

    logic              cfg_en;
    logic [SEL_W-1:0]  cfg_sel;
    mclk_fac_t         cfg_fac;
    mclk_fac_t         nxt_fac;
    mclk_fac_t         act_fac;
    logic              sel_chg;
    logic              sel_strobe;
    logic              pre_pass;
    logic              per_wrap;
    logic [PCNT_W-1:0] pre_cnt;
    logic [DIV_W-1:0]  div_cnt;
    logic [KW-1:0]     phase_idx;
    logic [NW-1:0]     per_n;
    logic [NW-1:0]     fall_idx;
    logic              fall_hit;
    logic              idle;
    logic              clr;

    modclk_regs #(
        .ADDR_W  (ADDR_W),
        .REG_ADDR(REG_ADDR),
        .SEL_W   (SEL_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_be  (wr_be),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .cfg_en (cfg_en),
        .cfg_sel(cfg_sel),
        .cfg_fac(cfg_fac),
        .nxt_fac(nxt_fac),
        .sel_chg(sel_chg)
    );

    modclk_src_sel #(
        .NUM_SRC(NUM_SRC),
        .SEL_W  (SEL_W)
    ) u_sel (
        .src_tick(src_tick),
        .sel     (cfg_sel),
        .strobe  (sel_strobe)
    );

    modclk_prescale #(
        .EXP_W(PRE_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .strobe(sel_strobe),
        .pexp  (act_fac.pexp),
        .cnt   (pre_cnt),
        .pass  (pre_pass)
    );

    modclk_divide #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .step (pre_pass),
        .mdiv (act_fac.mdiv),
        .cnt  (div_cnt),
        .wrap (per_wrap)
    );

    // Position of the current strobe within the period, and the period length.
    assign phase_idx = (KW'(div_cnt) << act_fac.pexp) | KW'(pre_cnt);
    assign per_n     = (NW'(act_fac.mdiv) + NW'(1)) << act_fac.pexp;
    assign fall_idx  = (per_n >> 1) - NW'(1);
    assign fall_hit  = sel_strobe && (per_n != NW'(1)) && ({1'b0, phase_idx} == fall_idx);

    assign idle = !cfg_en && !clk_out;
    assign clr  = idle || sel_chg;

    // Active factors: reloaded only at a period boundary, on a restart, or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 act_fac <= '0;
        else if (clr || per_wrap)   act_fac <= nxt_fac;
    end

    // Level output: rises at period end, falls at mid-period, and parks low when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                                            clk_out <= 1'b0;
        else if (idle)                                         clk_out <= 1'b0;
        else if (sel_chg)                                      clk_out <= clk_out;
        else if (per_wrap && cfg_en)                           clk_out <= 1'b1;
        else if (fall_hit)                                     clk_out <= 1'b0;
        else if (!cfg_en && sel_strobe && per_n == NW'(1))     clk_out <= 1'b0;
    end

    // Enable pulse: one cycle after each period-closing strobe while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_en <= 1'b0;
        else        clk_en <= per_wrap && cfg_en && !sel_chg;
    end

    // R9
    src_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> $past(sel_strobe));

    // R5
    rise_with_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out) |-> clk_en);

    // R7
    park_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !clk_out) |=> !clk_out);

    // R7
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> $past(cfg_en));

endmodule

// File: tb/tb_modclk_gen.sv
// Self-checking bench for modclk_gen. It walks a vector table of factor sets,
// then runs directed tests for reset, register masking, reload timing,
// select change and disable.
module tb_modclk_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] src_tick = '0;
    logic        clk_en;
    logic        clk_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    modclk_gen dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .src_tick(src_tick),
        .clk_en  (clk_en),
        .clk_out (clk_out)
    );

    // Vector layout: {sel[3:0], p[1:0], m[3:0]}
    localparam int NVEC = 8;
    localparam logic [9:0] VEC [NVEC] = '{
        {4'd0,  2'd0, 4'd0},
        {4'd1,  2'd0, 4'd1},
        {4'd3,  2'd1, 4'd2},
        {4'd5,  2'd2, 4'd0},
        {4'd15, 2'd3, 4'd15},
        {4'd7,  2'd2, 4'd4},
        {4'd9,  2'd0, 4'd14},
        {4'd2,  2'd1, 4'd0}
    };

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src_tick = '0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic reg_write(input logic [31:0] d, input logic [3:0] be, input logic [7:0] a);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_be = be; wr_addr = a;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One selected strobe, then one cycle of strobes on every other source.
    task automatic strobe(input int idx, output logic e, output logic o, output logic noise);
        @(negedge clk);
        src_tick = '0;
        src_tick[idx] = 1'b1;
        @(negedge clk);
        e = clk_en; o = clk_out;
        src_tick = ~(16'd1 << idx);
        @(negedge clk);
        noise = clk_en;
        src_tick = '0;
    endtask

    task automatic count_to_en(input int idx, input int lim, output int n);
        logic e, o, z;
        n = -1;
        for (int i = 1; i <= lim; i++) begin
            strobe(idx, e, o, z);
            if (e) begin n = i; break; end
        end
    endtask

    task automatic run_vec(input logic [9:0] v);
        int sel, p, m, nn, bad_en, bad_out, noise_cnt;
        logic e, o, z;
        sel = int'(v[9:6]); p = int'(v[5:4]); m = int'(v[3:0]);
        nn = (m + 1) << p;
        bad_en = 0; bad_out = 0; noise_cnt = 0;
        do_reset();
        reg_write(32'h8000_0000 | (32'(sel) << 24) | (32'(p) << 16) | 32'(m), 4'hF, 8'h00);
        for (int i = 1; i <= 2 * nn; i++) begin
            int k;
            logic xe, xo;
            strobe(sel, e, o, z);
            k  = (i - 1) % nn;
            xe = (i % nn) == 0;
            xo = (nn == 1) ? 1'b1 : ((k == nn - 1) || (i > nn && k < nn / 2 - 1));
            if (e !== xe) bad_en++;
            if (o !== xo) bad_out++;
            if (z !== 1'b0) noise_cnt++;
        end
        chk($sformatf("R3 pulse spacing sel=%0d p=%0d m=%0d", sel, p, m), bad_en, 0);
        chk($sformatf("R5 level shape sel=%0d p=%0d m=%0d", sel, p, m), bad_out, 0);
        chk($sformatf("R4 other sources ignored sel=%0d", sel), noise_cnt, 0);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic e, o, z;
        int n, flags;

        // R1 reset state
        do_reset();
        @(negedge clk);
        chk("R1 register after reset", rd_data, 0);
        chk("R1 clk_en after reset", clk_en, 0);
        chk("R1 clk_out after reset", clk_out, 0);
        flags = 0;
        for (int i = 0; i < 6; i++) begin
            strobe(0, e, o, z);
            if (e || o || z) flags++;
        end
        chk("R1 disabled ignores strobes", flags, 0);

        // R2 masking, byte strobes, address decode
        reg_write(32'hFFFF_FFFF, 4'hF, 8'h00);
        @(negedge clk);
        chk("R2 unused bits read zero", rd_data, 32'h8F03_000F);
        reg_write(32'h0000_0000, 4'h1, 8'h00);
        @(negedge clk);
        chk("R2 byte strobe limits write", rd_data, 32'h8F03_0000);
        reg_write(32'h0000_0000, 4'hF, 8'h04);
        @(negedge clk);
        chk("R2 other address write ignored", rd_data, 32'h8F03_0000);
        rd_addr = 8'h04;
        @(negedge clk);
        chk("R2 other address reads zero", rd_data, 0);
        rd_addr = 8'h00;

        // R3 R4 R5 vector walk
        for (int v = 0; v < NVEC; v++) run_vec(VEC[v]);

        // R6 mid-period factor change waits for the boundary
        do_reset();
        reg_write(32'h8000_0003, 4'hF, 8'h00);
        count_to_en(0, 20, n);
        chk("R3 first period N=4", n, 4);
        strobe(0, e, o, z);
        reg_write(32'h8000_0001, 4'hF, 8'h00);
        count_to_en(0, 20, n);
        chk("R6 old period completes", n, 3);
        count_to_en(0, 20, n);
        chk("R6 new factor next period", n, 2);

        // R6 write in the same cycle as the period-closing strobe
        do_reset();
        reg_write(32'h8000_0003, 4'hF, 8'h00);
        for (int i = 0; i < 3; i++) strobe(0, e, o, z);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h8000_0001; wr_be = 4'hF; wr_addr = 8'h00;
        src_tick = 16'h0001;
        @(negedge clk);
        wr_en = 1'b0; src_tick = '0;
        chk("R6 closing pulse with coincident write", clk_en, 1);
        count_to_en(0, 20, n);
        chk("R6 coincident write applies next period", n, 2);

        // R8 select change restarts counting
        do_reset();
        reg_write(32'h8000_0003, 4'hF, 8'h00);
        strobe(0, e, o, z);
        strobe(0, e, o, z);
        reg_write(32'h8100_0003, 4'hF, 8'h00);
        count_to_en(1, 20, n);
        chk("R8 counters restart on new source", n, 4);

        // R7 disable during high phase
        do_reset();
        reg_write(32'h8000_0003, 4'hF, 8'h00);
        count_to_en(0, 20, n);
        chk("R7 high before disable", clk_out, 1);
        reg_write(32'h0000_0003, 4'hF, 8'h00);
        strobe(0, e, o, z);
        chk("R7 high phase completes", o, 1);
        strobe(0, e, o, z);
        chk("R7 drops at mid-period", o, 0);
        flags = 0;
        for (int i = 0; i < 8; i++) begin
            strobe(0, e, o, z);
            if (e || o) flags++;
        end
        chk("R7 stays parked", flags, 0);

        // R7 disable while low parks at once
        do_reset();
        reg_write(32'h8000_0003, 4'hF, 8'h00);
        strobe(0, e, o, z);
        reg_write(32'h0000_0003, 4'hF, 8'h00);
        flags = 0;
        for (int i = 0; i < 8; i++) begin
            strobe(0, e, o, z);
            if (e || o) flags++;
        end
        chk("R7 disabled while low, no output", flags, 0);

        // R9 no pulse without a selected strobe
        do_reset();
        reg_write(32'h8000_0000, 4'hF, 8'h00);
        flags = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (clk_en) flags++;
        end
        chk("R9 no pulse without source strobe", flags, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule